// File: doc/BRIEF.md
# IDE Channel Port Access Decoder

This block sits between a host I/O bus and the register set of one IDE channel. The host reaches the channel through two address windows. The first is an eight-byte command/data window. The second is a four-byte control window. Every host access carries the following:

- a window select
- a byte offset
- a size code
- a read or write indication
- write data

The decoder sorts each access into one of four downstream operations:

- a task-file register access
- a 16-bit data-port transfer
- a 32-bit data-port transfer
- a device-control / alternate-status access

It presents that operation as a single-cycle strobe on the device-register interface. Accesses with no legal meaning float: a read returns all ones across its width, and a write is dropped.

The block accepts one access per cycle without stalling. An accepted access drives its downstream strobe one cycle later. A read then returns formatted data one cycle after its strobe, with a valid flag. A floated read gets its response at that same point, so every read completes two cycles after it is presented. Writes never produce a response. Byte lanes are little-endian throughout: the byte at the lowest offset occupies bits 7:0.

Top module: `ide_port_decoder`

## Requirements
- R1: A 1-byte access (size code 0) at any offset 0..7 of the command/data window (window select 0) strobes the task-file target (target code 0) one cycle after it is presented. The register index equals the offset.
- R2: A 2-byte access (size code 1) at command/data offset 0 strobes the 16-bit data-port target (target code 1).
- R3: A 4-byte access (size code 2) at command/data offset 0 strobes the 32-bit data-port target (target code 2).
- R4: A 2- or 4-byte access at any nonzero command/data offset raises no strobe. As a read it returns 0xFFFF or 0xFFFFFFFF. As a write it leaves every downstream register unchanged.
- R5: In the control window (window select 1), a 1-byte access at offset 2 strobes the control target (target code 3). A read there returns the alternate status byte, and a write there carries the new device-control byte.
- R6: Every other control-window access raises no strobe. As a read it returns all ones for its width: 0xFF, 0xFFFF or 0xFFFFFFFF.
- R7: A read response is valid exactly one cycle after the read strobe, or two cycles after a floated read is presented. The response holds the device data in its low lanes, with bits 7:0 first, and zeros above the access width.
- R8: Write data reaches the device unchanged in the lanes covered by the access width, in little-endian order, and is zero in every lane above.
- R9: Writes never raise the response valid flag. Asserting reset discards any read that is still in flight, and keeps both strobes and the response valid flag low.
- R10: The reserved size code 3 is never decoded. It reads as 0xFFFFFFFF and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Host access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 1 | 0 = command/data window, 1 = control window |
| req_addr | input | 3 | Byte offset inside the selected window |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| req_wdata | input | 32 | Host write data, little-endian lanes |
| dev_rd | output | 1 | Single-cycle read strobe to the device registers |
| dev_wr | output | 1 | Single-cycle write strobe to the device registers |
| dev_tgt | output | 2 | Target: 0 task file, 1 data16, 2 data32, 3 control |
| dev_reg | output | 3 | Task-file register index (window offset) |
| dev_wdata | output | 32 | Write data, lanes above the access width zeroed |
| dev_rdata | input | 32 | Device read data, valid in the strobe cycle |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |

## Verification
The bench builds the block with its default parameters: an eight-byte command/data window, a four-byte control window with its live byte at offset 2, and a 32-bit data path. With these sizes every offset and size code in both windows can be swept outright. The sweep covers each legal slot, every misaligned wide access, and the reserved size code. The bench also runs back-to-back reads to exercise the pipeline, and asserts reset while a read is in flight.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_TASKFILE = 2'd0,
    TGT_DATA16   = 2'd1,
    TGT_DATA32   = 2'd2,
    TGT_CONTROL  = 2'd3
  } tgt_e;

endpackage

// File: rtl/ide_dec_classify.sv
module ide_dec_classify
  import ide_dec_pkg::*;
#(
  parameter int DATA_SPAN = 8,
  parameter int CTRL_OFS  = 2,
  parameter int AW        = 3
) (
  input  logic          win_ctrl,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output logic          hit,
  output tgt_e          tgt
);

  localparam logic [AW:0]   DSPAN = DATA_SPAN[AW:0];
  localparam logic [AW-1:0] COFS  = CTRL_OFS[AW-1:0];

  logic in_data;
  assign in_data = ({1'b0, addr} < DSPAN);

  always_comb begin
    hit = 1'b0;
    tgt = TGT_TASKFILE;
    if (!win_ctrl) begin
      if (in_data) begin
        case (size)
          SZ_BYTE: hit = 1'b1;
          SZ_HALF: if (addr == '0) begin hit = 1'b1; tgt = TGT_DATA16; end
          SZ_WORD: if (addr == '0) begin hit = 1'b1; tgt = TGT_DATA32; end
          default: hit = 1'b0;
        endcase
      end
    end else if ((addr == COFS) && (size == SZ_BYTE)) begin
      hit = 1'b1;
      tgt = TGT_CONTROL;
    end
  end

endmodule

// File: rtl/ide_dec_lanes.sv
module ide_dec_lanes
  import ide_dec_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    size,
  output logic [DW-1:0] mask
);

  localparam int NB = DW / 8;
  localparam int CW = $clog2(NB) + 1;

  logic [CW-1:0] nbytes;

  always_comb begin
    case (size)
      SZ_BYTE: nbytes = CW'(1);
      SZ_HALF: nbytes = CW'(2);
      default: nbytes = CW'(NB);
    endcase
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign mask[8*b +: 8] = {8{(CW'(b) < nbytes)}};
  end

endmodule

// File: rtl/ide_dec_issue.sv
module ide_dec_issue
  import ide_dec_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          hit,
  input  tgt_e          tgt,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] lane_mask,
  output logic          dev_rd,
  output logic          dev_wr,
  output tgt_e          dev_tgt,
  output logic [AW-1:0] dev_reg,
  output logic [DW-1:0] dev_wdata,
  output logic          rd_pend,
  output logic          rd_float,
  output logic [1:0]    rd_size
);

  logic          v_q, v_d;
  logic          w_q, w_d;
  logic          hit_q, hit_d;
  tgt_e          tgt_q, tgt_d;
  logic [AW-1:0] reg_q, reg_d;
  logic [1:0]    size_q, size_d;
  logic [DW-1:0] wd_q, wd_d;
  logic          ld_en;

  assign ld_en = req_valid;

  always_comb begin
    v_d    = req_valid;
    w_d    = w_q;
    hit_d  = hit_q;
    tgt_d  = tgt_q;
    reg_d  = reg_q;
    size_d = size_q;
    wd_d   = wd_q;
    if (ld_en) begin
      w_d    = req_write;
      hit_d  = hit;
      tgt_d  = tgt;
      reg_d  = addr;
      size_d = size;
      wd_d   = req_write ? (wdata & lane_mask) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      w_q   <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      v_q   <= v_d;
      w_q   <= w_d;
      hit_q <= hit_d;
    end
  end

  always_ff @(posedge clk) begin
    tgt_q  <= tgt_d;
    reg_q  <= reg_d;
    size_q <= size_d;
    wd_q   <= wd_d;
  end

  assign dev_rd    = v_q & ~w_q & hit_q;
  assign dev_wr    = v_q &  w_q & hit_q;
  assign dev_tgt   = tgt_q;
  assign dev_reg   = reg_q;
  assign dev_wdata = wd_q;
  assign rd_pend   = v_q & ~w_q;
  assign rd_float  = ~hit_q;
  assign rd_size   = size_q;

  // R1: never a read and a write strobe together
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dev_rd, dev_wr}));

  // R8: a write strobe follows a write request from the previous cycle
  a_r8_wr_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |-> $past(req_valid && req_write));

endmodule

// File: rtl/ide_dec_return.sv
module ide_dec_return
  import ide_dec_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_pend,
  input  logic          rd_float,
  input  logic [1:0]    rd_size,
  input  logic [DW-1:0] dev_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  logic [DW-1:0] width_mask;
  logic          vld_q, vld_d;
  logic [DW-1:0] dat_q, dat_d;
  logic          dat_en;

  ide_dec_lanes #(.DW(DW)) u_rsp_lanes (
    .size (rd_size),
    .mask (width_mask)
  );

  assign dat_en = rd_pend;

  always_comb begin
    vld_d = rd_pend;
    dat_d = dat_q;
    if (dat_en) begin
      dat_d = rd_float ? width_mask : (dev_rdata & width_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    dat_q <= dat_d;
  end

  assign rsp_valid = vld_q;
  assign rsp_rdata = dat_q;

  // R7: a response only ever follows a read pending in the issue stage
  a_r7_rsp_after_pend: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_pend));

endmodule

// File: rtl/ide_port_decoder.sv
module ide_port_decoder
  import ide_dec_pkg::*;
#(
  parameter int DATA_SPAN = 8,
  parameter int CTRL_SPAN = 4,
  parameter int CTRL_OFS  = 2,
  parameter int DW        = 32,
  localparam int AW       = $clog2(DATA_SPAN > CTRL_SPAN ? DATA_SPAN : CTRL_SPAN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_win,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  output logic          dev_rd,
  output logic          dev_wr,
  output logic [1:0]    dev_tgt,
  output logic [AW-1:0] dev_reg,
  output logic [DW-1:0] dev_wdata,
  input  logic [DW-1:0] dev_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  logic          cls_hit;
  tgt_e          cls_tgt;
  logic [DW-1:0] req_mask;
  tgt_e          iss_tgt;
  logic          rd_pend;
  logic          rd_float;
  logic [1:0]    rd_size;

  ide_dec_classify #(
    .DATA_SPAN (DATA_SPAN),
    .CTRL_OFS  (CTRL_OFS),
    .AW        (AW)
  ) u_classify (
    .win_ctrl (req_win),
    .addr     (req_addr),
    .size     (req_size),
    .hit      (cls_hit),
    .tgt      (cls_tgt)
  );

  ide_dec_lanes #(.DW(DW)) u_req_lanes (
    .size (req_size),
    .mask (req_mask)
  );

  ide_dec_issue #(.AW(AW), .DW(DW)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .hit       (cls_hit),
    .tgt       (cls_tgt),
    .addr      (req_addr),
    .size      (req_size),
    .wdata     (req_wdata),
    .lane_mask (req_mask),
    .dev_rd    (dev_rd),
    .dev_wr    (dev_wr),
    .dev_tgt   (iss_tgt),
    .dev_reg   (dev_reg),
    .dev_wdata (dev_wdata),
    .rd_pend   (rd_pend),
    .rd_float  (rd_float),
    .rd_size   (rd_size)
  );

  assign dev_tgt = iss_tgt;

  ide_dec_return #(.DW(DW)) u_return (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_pend   (rd_pend),
    .rd_float  (rd_float),
    .rd_size   (rd_size),
    .dev_rdata (dev_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // R2: 2-byte access at data offset 0 strobes the 16-bit data port
  a_r2_data16: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_win && req_addr == '0 && req_size == 2'd1)
      |=> ((dev_rd || dev_wr) && dev_tgt == 2'd1));

  // R4: wide access at a nonzero data offset raises no strobe
  a_r4_misaligned_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_win && req_addr != '0 && req_size != 2'd0)
      |=> (!dev_rd && !dev_wr));

  // R6: control-window access off the live byte raises no strobe
  a_r6_ctrl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_win && !(req_addr == AW'(CTRL_OFS) && req_size == 2'd0))
      |=> (!dev_rd && !dev_wr));

  // R9: a write never yields a response two cycles on
  a_r9_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> ##1 !rsp_valid);

endmodule

// File: tb/ide_port_decoder_tb_top.sv
module ide_port_decoder_tb_top;

  localparam logic [7:0] ALT_ST = 8'h58;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic        req_win;
  logic [2:0]  req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        dev_rd;
  logic        dev_wr;
  logic [1:0]  dev_tgt;
  logic [2:0]  dev_reg;
  logic [31:0] dev_wdata;
  logic [31:0] dev_rdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  ide_port_decoder dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_win   (req_win),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .dev_rd    (dev_rd),
    .dev_wr    (dev_wr),
    .dev_tgt   (dev_tgt),
    .dev_reg   (dev_reg),
    .dev_wdata (dev_wdata),
    .dev_rdata (dev_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- device register stub ----------------
  logic [7:0]  tf [8];
  logic [31:0] data_word;
  logic [7:0]  ctrl_byte;

  initial begin
    for (int i = 0; i < 8; i++) tf[i] = 8'h00;
    data_word = 32'h89AB_CDEF;
    ctrl_byte = 8'h00;
  end

  always_comb begin
    case (dev_tgt)
      2'd0:    dev_rdata = {24'hA5A5A5, tf[dev_reg]};
      2'd1,
      2'd2:    dev_rdata = data_word;
      default: dev_rdata = {24'hFFFFFF, ALT_ST};
    endcase
  end

  always @(posedge clk) begin
    if (dev_wr) begin
      case (dev_tgt)
        2'd0:    tf[dev_reg] <= dev_wdata[7:0];
        2'd1:    data_word[15:0] <= dev_wdata[15:0];
        2'd2:    data_word <= dev_wdata;
        default: ctrl_byte <= dev_wdata[7:0];
      endcase
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    int          cyc;
    bit          has;
    bit          wr;
    logic [1:0]  tgt;
    logic [2:0]  rg;
    logic [31:0] wd;
    string       tag;
  } stb_t;

  typedef struct {
    int          cyc;
    logic [31:0] d;
    string       tag;
  } rsp_t;

  stb_t sq[$];
  rsp_t rq[$];

  logic [7:0]  sh_tf [8];
  logic [31:0] sh_data;

  initial begin
    for (int i = 0; i < 8; i++) sh_tf[i] = 8'h00;
    sh_data = 32'h89AB_CDEF;
  end

  always @(negedge clk) begin
    stb_t e;
    rsp_t r;
    if (rst_n) begin
      if (sq.size() > 0 && sq[0].cyc == cyc) begin
        e = sq.pop_front();
        chk((dev_rd | dev_wr) == e.has, e.tag, "strobe", {30'd0, dev_wr, dev_rd},
            {30'd0, e.has & e.wr, e.has & ~e.wr});
        if (e.has) begin
          chk(dev_wr == e.wr, e.tag, "direction", {31'd0, dev_wr}, {31'd0, e.wr});
          chk(dev_tgt == e.tgt, e.tag, "target", {30'd0, dev_tgt}, {30'd0, e.tgt});
          if (e.tgt == 2'd0)
            chk(dev_reg == e.rg, e.tag, "reg index", {29'd0, dev_reg}, {29'd0, e.rg});
          if (e.wr)
            chk(dev_wdata == e.wd, e.tag, "wdata", dev_wdata, e.wd);
        end
      end else if (dev_rd | dev_wr) begin
        chk(1'b0, "R4", "unexpected strobe", {30'd0, dev_wr, dev_rd}, 32'd0);
      end
      if (rq.size() > 0 && rq[0].cyc == cyc) begin
        r = rq.pop_front();
        chk(rsp_valid == 1'b1, r.tag, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk(rsp_rdata == r.d, r.tag, "rsp_rdata", rsp_rdata, r.d);
      end else if (rsp_valid) begin
        chk(1'b0, "R9", "unexpected response", 32'd1, 32'd0);
      end
    end
  end

  function automatic logic [31:0] wmask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // driver: presents one access and pushes what it must produce
  task automatic access(input bit win, input bit wr, input logic [2:0] a,
                        input logic [1:0] sz, input logic [31:0] wd, input string tag);
    stb_t e;
    rsp_t r;
    logic [31:0] m;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_win   = win;
    req_addr  = a;
    req_size  = sz;
    req_wdata = wd;
    m = wmask(sz);
    e.cyc = cyc + 1; e.wr = wr; e.rg = a; e.wd = wd & m; e.tag = tag;
    e.has = 1'b0; e.tgt = 2'd0;
    if (!win) begin
      if (sz == 2'd0) begin e.has = 1'b1; e.tgt = 2'd0; end
      else if (sz == 2'd1 && a == 3'd0) begin e.has = 1'b1; e.tgt = 2'd1; end
      else if (sz == 2'd2 && a == 3'd0) begin e.has = 1'b1; e.tgt = 2'd2; end
    end else if (a == 3'd2 && sz == 2'd0) begin
      e.has = 1'b1; e.tgt = 2'd3;
    end
    sq.push_back(e);
    if (!wr) begin
      r.cyc = cyc + 2; r.tag = tag;
      if (!e.has)            r.d = m;
      else case (e.tgt)
        2'd0:    r.d = {24'd0, sh_tf[a]};
        2'd1:    r.d = sh_data & 32'h0000_FFFF;
        2'd2:    r.d = sh_data;
        default: r.d = {24'd0, ALT_ST};
      endcase
      rq.push_back(r);
    end else if (e.has) begin
      case (e.tgt)
        2'd0:    sh_tf[a] = wd[7:0];
        2'd1:    sh_data[15:0] = wd[15:0];
        2'd2:    sh_data = wd;
        default: ;
      endcase
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    if (n > 1) repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_win = 1'b0;
    req_addr = '0; req_size = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R9", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk(dev_rd == 1'b0 && dev_wr == 1'b0, "R9", "reset strobes",
        {30'd0, dev_wr, dev_rd}, 32'd0);
    rst_n = 1'b1;
    idle(2);

    // R1 R8: byte writes to every task-file offset, then reads back (R7)
    for (int i = 0; i < 8; i++)
      access(1'b0, 1'b1, i[2:0], 2'd0, 32'hDEAD_BE00 | i, "R1");
    for (int i = 0; i < 8; i++)
      access(1'b0, 1'b0, i[2:0], 2'd0, 32'h0, "R7");
    idle(3);

    // R2 R3 R8: data port transfers, little-endian lanes
    access(1'b0, 1'b1, 3'd0, 2'd1, 32'hCAFE_1234, "R2");
    access(1'b0, 1'b0, 3'd0, 2'd1, 32'h0, "R2");
    access(1'b0, 1'b1, 3'd0, 2'd2, 32'h1122_3344, "R3");
    access(1'b0, 1'b0, 3'd0, 2'd2, 32'h0, "R3");
    access(1'b0, 1'b0, 3'd0, 2'd0, 32'h0, "R8");
    idle(3);

    // R4: misaligned wide accesses float
    for (int i = 1; i < 8; i++) begin
      access(1'b0, 1'b0, i[2:0], 2'd1, 32'h0, "R4");
      access(1'b0, 1'b0, i[2:0], 2'd2, 32'h0, "R4");
      access(1'b0, 1'b1, i[2:0], 2'd2, 32'h0102_0304, "R4");
      access(1'b0, 1'b1, i[2:0], 2'd1, 32'h0000_7777, "R4");
    end
    idle(3);
    // ignored writes left data and task file untouched
    access(1'b0, 1'b0, 3'd0, 2'd2, 32'h0, "R4");
    for (int i = 1; i < 8; i++)
      access(1'b0, 1'b0, i[2:0], 2'd0, 32'h0, "R4");
    idle(3);

    // R5: the live control byte
    access(1'b1, 1'b1, 3'd2, 2'd0, 32'hFFFF_FF0E, "R5");
    access(1'b1, 1'b0, 3'd2, 2'd0, 32'h0, "R5");
    idle(3);
    chk(ctrl_byte == 8'h0E, "R5", "device control stored", {24'd0, ctrl_byte}, 32'h0E);

    // R6: all other control-window accesses float
    for (int i = 0; i < 8; i++) begin
      for (int s = 0; s < 3; s++) begin
        if (!(i == 2 && s == 0)) begin
          access(1'b1, 1'b0, i[2:0], s[1:0], 32'h0, "R6");
          access(1'b1, 1'b1, i[2:0], s[1:0], 32'h0000_0033, "R6");
        end
      end
    end
    idle(3);
    chk(ctrl_byte == 8'h0E, "R6", "device control unchanged", {24'd0, ctrl_byte}, 32'h0E);

    // R10: reserved size code
    access(1'b0, 1'b0, 3'd0, 2'd3, 32'h0, "R10");
    access(1'b0, 1'b1, 3'd0, 2'd3, 32'h5555_5555, "R10");
    access(1'b1, 1'b0, 3'd2, 2'd3, 32'h0, "R10");
    access(1'b0, 1'b0, 3'd0, 2'd2, 32'h0, "R10");
    idle(3);

    // R9: reset while a read is in flight
    access(1'b0, 1'b0, 3'd3, 2'd0, 32'h0, "R9");
    void'(rq.pop_back());
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9", "flushed response", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9", "response held low", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    idle(3);
    access(1'b0, 1'b0, 3'd3, 2'd0, 32'h0, "R9");
    idle(4);

    chk(sq.size() == 0 && rq.size() == 0, "R7", "scoreboard drained",
        sq.size() + rq.size(), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule